// File: doc/BRIEF.md
# Indexed Clock Channel Control Bank

This block holds the clock routing for a set of peripheral channels. Each channel picks one of several generator tick streams, has an enable and has a sticky write lock. Software reaches the channels indirectly. A write that carries only the low byte of the channel register selects a channel. Reads and later field writes then act on the selected channel. A full write names the channel and sets its fields in the same access.

Every channel drives one bit of a clock-enable vector. That bit follows the tick of the chosen generator while the channel runs. When software clears the enable, the channel keeps reporting itself as running until a tick arrives on generator 0, the always-running default source. Only then does it report that it has stopped. A soft reset bit in the control register returns the channels to their defaults and leaves the locks alone. Only the power-on reset input clears a lock.

Top module: `clk_route_bank`

## Requirements
- R1: A write to the channel register (address 2) with only byte strobe 0 set loads the selection from bits [CH_W-1:0]. It changes no field of any channel, and a later read of address 2 returns the newly selected channel.
- R2: A write to address 2 with strobe 1 or strobe 2 set updates one channel. That channel is the one given in byte 0 when strobe 0 is also set, and otherwise the current selection. Strobe 1 writes the generator from bits [8 +: GEN_W]. Strobe 2 writes the enable from bit 16.
- R3: Bit 17 written as 1 under strobe 2 locks the channel. From then on every field write to that channel is silently ignored, and the lock reads back as 1 in bit 17. Soft reset keeps the lock.
- R4: Writing 1 to bit 0 of the control register (address 0, strobe 0) starts a soft reset. The reset lasts SRST_CYC cycles and reads back as 1 in bit 0 while it runs. It clears the selection and every channel's generator, enable and running state, and all clock-enable outputs go low.
- R5: The power-on reset input rst clears every field, including the locks, and sets all outputs and the read data to 0.
- R6: While a channel is enabled, its bit of ch_clk_en is the tick of its selected generator, delayed by one register stage.
- R7: After the enable is cleared, the channel's output bit stays low from the following cycle on. Bit 16 of the readback keeps reading 1 until the first cycle with gen_tick[0] high, and reads 0 after that.
- R8: Each field write to address 2 (strobe 1 or 2) makes bit 0 of the status register (address 1) read 1 for BUSY_CYC consecutive reads after the write, then 0.
- R9: bus_rdata is registered. It shows the register at bus_addr one clock edge after the address is presented, and it reflects every write completed at earlier edges.
- R10: If a write sets the enable of a stopping channel in the same cycle that gen_tick[0] is high, the enable wins and the channel keeps reading as running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 channel |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Registered read data |
| gen_tick | input | N_GEN | Tick from each generator |
| ch_clk_en | output | N_CH | Per-channel clock enable |

## Verification
Two things can happen to a channel in the same cycle: a register write to it, and a tick on the default generator that completes a pending stop. The bench clears a channel's enable and then holds ticks off. In one cycle it drives gen_tick[0] high together with a write that enables the same channel again, and the readback must still show the channel running. A separate directed step lets the generator-0 tick arrive with no write, and that tick alone must clear the running bit. This confirms that the write, not the tick, decided the outcome of the combined cycle.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CHAN = 2'd2;
  localparam int GEN_LSB  = 8;
  localparam int EN_BIT   = 16;
  localparam int LOCK_BIT = 17;
endpackage

// File: rtl/clkbank_timer.sv
module clkbank_timer #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R8 / R4: a load always opens a window
  a_r8_load_opens: assert property (@(posedge clk) disable iff (rst)
    load |=> active);
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CYC));
endmodule

// File: rtl/clkbank_slot.sv
module clkbank_slot #(
  parameter int N_GEN = 4,
  localparam int GEN_W = (N_GEN > 1) ? $clog2(N_GEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_gen,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [GEN_W-1:0] wdata_gen,
  input  logic             wdata_en,
  input  logic [N_GEN-1:0] gen_tick,
  output logic [GEN_W-1:0] gen_q,
  output logic             run_q,
  output logic             lock_q,
  output logic             clk_en_q
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= '0; en_q <= 1'b0; run_q <= 1'b0; lock_q <= 1'b0; clk_en_q <= 1'b0;
    end else if (clr) begin
      gen_q <= '0; en_q <= 1'b0; run_q <= 1'b0; clk_en_q <= 1'b0;
    end else begin
      if (!lock_q) begin
        if (wr_gen)  gen_q  <= wdata_gen;
        if (wr_en)   en_q   <= wdata_en;
        if (wr_lock) lock_q <= 1'b1;
      end
      if (!lock_q && wr_en && wdata_en) run_q <= 1'b1;
      else if (!en_q && gen_tick[0])    run_q <= 1'b0;
      clk_en_q <= en_q & gen_tick[gen_q];
    end
  end

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_r3_locked_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !clr) |=> ($stable(gen_q) && $stable(en_q)));
  a_r6_out_only_when_running: assert property (@(posedge clk) disable iff (rst)
    clk_en_q |-> run_q);
  a_r7_stop_needs_default_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> ($past(gen_tick[0]) || $past(clr)));
endmodule

// File: rtl/clk_route_bank.sv
module clk_route_bank #(
  parameter int N_CH     = 8,
  parameter int N_GEN    = 4,
  parameter int BUSY_CYC = 3,
  parameter int SRST_CYC = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic [clkbank_pkg::ADDR_W-1:0] bus_addr,
  input  logic [31:0]                  bus_wdata,
  input  logic [3:0]                   bus_be,
  output logic [31:0]                  bus_rdata,
  input  logic [N_GEN-1:0]             gen_tick,
  output logic [N_CH-1:0]              ch_clk_en
);
  import clkbank_pkg::*;
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int GEN_W = (N_GEN > 1) ? $clog2(N_GEN) : 1;

  logic             srst_active, busy_active;
  logic [CH_W-1:0]  sel_q, target;
  logic             chan_acc, cfg_wr, srst_start;
  logic [GEN_W-1:0] gen_a  [N_CH];
  logic             run_a  [N_CH];
  logic             lock_a [N_CH];

  assign chan_acc   = bus_wr && (bus_addr == A_CHAN) && !srst_active;
  assign cfg_wr     = chan_acc && (bus_be[1] || bus_be[2]);
  assign srst_start = bus_wr && (bus_addr == A_CTRL) && bus_be[0] && bus_wdata[0]
                      && !srst_active;
  assign target     = bus_be[0] ? bus_wdata[CH_W-1:0] : sel_q;

  always_ff @(posedge clk) begin
    if (rst || srst_active)        sel_q <= '0;
    else if (chan_acc && bus_be[0]) sel_q <= bus_wdata[CH_W-1:0];
  end

  clkbank_timer #(.CYC(BUSY_CYC)) i_busy (
    .clk(clk), .rst(rst), .load(cfg_wr), .active(busy_active));
  clkbank_timer #(.CYC(SRST_CYC)) i_srst (
    .clk(clk), .rst(rst), .load(srst_start), .active(srst_active));

  for (genvar i = 0; i < N_CH; i++) begin : g_slot
    logic hit;
    assign hit = cfg_wr && (target == CH_W'(i));
    clkbank_slot #(.N_GEN(N_GEN)) i_slot (
      .clk(clk), .rst(rst), .clr(srst_active),
      .wr_gen(hit && bus_be[1]),
      .wr_en(hit && bus_be[2]),
      .wr_lock(hit && bus_be[2] && bus_wdata[LOCK_BIT]),
      .wdata_gen(bus_wdata[GEN_LSB +: GEN_W]),
      .wdata_en(bus_wdata[EN_BIT]),
      .gen_tick(gen_tick),
      .gen_q(gen_a[i]), .run_q(run_a[i]), .lock_q(lock_a[i]),
      .clk_en_q(ch_clk_en[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      bus_rdata <= '0;
      case (bus_addr)
        A_CTRL: bus_rdata[0] <= srst_active;
        A_STAT: bus_rdata[0] <= busy_active;
        A_CHAN: begin
          bus_rdata[CH_W-1:0]         <= sel_q;
          bus_rdata[GEN_LSB +: GEN_W] <= gen_a[sel_q];
          bus_rdata[EN_BIT]           <= run_a[sel_q];
          bus_rdata[LOCK_BIT]         <= lock_a[sel_q];
        end
        default: ;
      endcase
    end
  end

  a_r8_busy_after_cfg: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> busy_active);
  a_r4_srst_silences: assert property (@(posedge clk) disable iff (rst)
    srst_active |=> (ch_clk_en == '0));
  a_r4_srst_clears_sel: assert property (@(posedge clk) disable iff (rst)
    srst_active |=> (sel_q == '0));
endmodule

// File: tb/test_clk_route_bank.sv
module test_clk_route_bank;
  localparam int N_CH = 8, N_GEN = 4;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  bus_be = '0;
  logic [N_GEN-1:0] gen_tick = '0;
  logic [N_CH-1:0]  ch_clk_en;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  clk_route_bank #(.N_CH(N_CH), .N_GEN(N_GEN), .BUSY_CYC(3), .SRST_CYC(4)) i_clk_route_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .gen_tick(gen_tick), .ch_clk_en(ch_clk_en));

  always #(TCLK/2) clk = ~clk;

  // {be, wdata, expected channel readback}
  localparam logic [67:0] VEC [8] = '{
    {4'b1111, 32'h0001_0203, 32'h0001_0203},  // R2 full write ch3 gen2 on
    {4'b0001, 32'h0000_0005, 32'h0000_0005},  // R1 select ch5
    {4'b0110, 32'h0001_0100, 32'h0001_0105},  // R2 fields to selected ch5
    {4'b0001, 32'h0000_0003, 32'h0001_0203},  // R1 reselect leaves ch3 intact
    {4'b0011, 32'h0000_0306, 32'h0000_0306},  // R2 generator only, ch6
    {4'b1111, 32'h0003_0107, 32'h0003_0107},  // R3 ch7 on and locked
    {4'b1111, 32'h0000_0207, 32'h0003_0107},  // R3 write to locked ch7 ignored
    {4'b0001, 32'h0000_0005, 32'h0001_0105}   // R1 back to ch5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(TCLK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    bread(2'd2, rd); chk("R5 chan after reset", rd, 32'h0);
    bread(2'd1, rd); chk("R5 status after reset", rd, 32'h0);
    bread(2'd0, rd); chk("R5 ctrl after reset", rd, 32'h0);
    chk("R5 outputs after reset", 32'(ch_clk_en), 32'h0);

    // table walk: R1 R2 R3 R9
    for (int k = 0; k < 8; k++) begin
      bwrite(2'd2, VEC[k][67:64], VEC[k][63:32]);
      repeat (4) @(negedge clk);
      bread(2'd2, rd);
      chk($sformatf("R1/R2/R3 row %0d", k), rd, VEC[k][31:0]);
    end

    // R8 busy window (ch6 generator rewrite)
    bwrite(2'd2, 4'b0011, 32'h0000_0306);
    bread(2'd1, rd); chk("R8 busy read 1", rd, 32'h1);
    bread(2'd1, rd); chk("R8 busy read 2", rd, 32'h1);
    bread(2'd1, rd); chk("R8 busy read 3", rd, 32'h1);
    bread(2'd1, rd); chk("R8 busy cleared", rd, 32'h0);

    // R6 output follows selected generator (ch3 gen2, ch5 gen1, ch7 gen1)
    @(negedge clk); gen_tick = 4'b0100;
    @(posedge clk); #1; chk("R6 gen2 tick", 32'(ch_clk_en), 32'h08);
    @(negedge clk); gen_tick = 4'b0010;
    @(posedge clk); #1; chk("R6 gen1 tick", 32'(ch_clk_en), 32'hA0);
    @(negedge clk); gen_tick = '0;

    // R7 disable of ch3 waits for a generator-0 tick
    bwrite(2'd2, 4'b1111, 32'h0000_0203);
    repeat (4) @(negedge clk);
    bread(2'd2, rd); chk("R7 still running", rd, 32'h0001_0203);
    gen_tick = 4'b0100;
    @(posedge clk); #1; chk("R7 output low", 32'(ch_clk_en & 8'h08), 32'h0);
    @(negedge clk); gen_tick = 4'b0001;
    @(negedge clk); gen_tick = '0;
    bread(2'd2, rd); chk("R7 stopped after default tick", rd, 32'h0000_0203);

    // R10 enable write and default tick in the same cycle
    bwrite(2'd2, 4'b1111, 32'h0001_0203);
    repeat (4) @(negedge clk);
    bwrite(2'd2, 4'b1111, 32'h0000_0203);
    repeat (4) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_be = 4'b1111; bus_wdata = 32'h0001_0203;
    gen_tick = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; gen_tick = '0;
    repeat (4) @(negedge clk);
    bread(2'd2, rd); chk("R10 enable wins over tick", rd, 32'h0001_0203);

    // R4 soft reset
    bwrite(2'd0, 4'b0001, 32'h1);
    bread(2'd0, rd); chk("R4 soft reset in progress", rd, 32'h1);
    repeat (5) @(negedge clk);
    bread(2'd0, rd); chk("R4 soft reset done", rd, 32'h0);
    bread(2'd2, rd); chk("R4 selection cleared", rd, 32'h0);
    gen_tick = 4'b1111;
    @(posedge clk); #1; chk("R4 outputs cleared", 32'(ch_clk_en), 32'h0);
    @(negedge clk); gen_tick = '0;
    bwrite(2'd2, 4'b0001, 32'h7);
    bread(2'd2, rd); chk("R4 lock kept through soft reset", rd, 32'h0002_0007);
    bwrite(2'd2, 4'b1111, 32'h0001_0107);
    repeat (4) @(negedge clk);
    bread(2'd2, rd); chk("R3 locked after soft reset", rd, 32'h0002_0007);

    // R5 power-on reset clears lock
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bwrite(2'd2, 4'b0001, 32'h7);
    bread(2'd2, rd); chk("R5 lock cleared", rd, 32'h0000_0007);
    bwrite(2'd2, 4'b1111, 32'h0001_0107);
    repeat (4) @(negedge clk);
    bread(2'd2, rd); chk("R5 writable again", rd, 32'h0001_0107);

    finish_run();
  end
endmodule